// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block forms the address front end of a synchronous burst static memory. Every input is sampled on the rising edge of one common clock. When either of two active-low address strobes is low at an edge, the external address is captured and a new four-beat burst starts at that address. There is no asynchronous path from the address pins to the array address.

After a load, an active-low advance input steps the burst one beat per edge. Only the low `BEAT_BITS` address bits move, so the burst stays inside its aligned group and the upper bits are held. A static mode strap chooses the beat order. In linear order each beat adds one, modulo the group size. In interleaved order the start bits are XORed with the beat count. The advance input held high suspends the burst and holds the address.

A burst-active flag shows that the current burst still has beats left to deliver. Holding the controller strobe low for every cycle, with the other strobe and the advance input high, gives single-access-only use: a new address is loaded on each cycle.

Top module: `burst_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, `arrayAddr` is 0 and `burstActive` is 0.
- R2: A low level on `procStrobeN` or on `ctrlStrobeN` at a clock edge loads `addrIn`. From the next cycle, `arrayAddr` equals `addrIn` and `burstActive` is 1.
- R3: When both strobes are low at the same edge, the address is loaded and `advanceN` has no effect on that edge.
- R4: With `modeInterleave` = 0, each edge with both strobes high and `advanceN` low sets the low `BEAT_BITS` of `arrayAddr` to (start low bits + beats taken) modulo 2^`BEAT_BITS`.
- R5: With `modeInterleave` = 1, the low bits of `arrayAddr` equal the start low bits XOR the beats taken (modulo 2^`BEAT_BITS`).
- R6: An edge with both strobes high and `advanceN` high leaves `arrayAddr` and `burstActive` unchanged.
- R7: Advancing never changes `arrayAddr` bits [`ADDR_W`-1:`BEAT_BITS`]. Those bits change only on a load.
- R8: An advance taken from the last beat wraps back to the first beat address of the same group.
- R9: `burstActive` stays 1 through the last beat of a burst. It falls on the advance that wraps past the last beat, and it stays 0 until the next load.
- R10: With `ctrlStrobeN` held low and `procStrobeN` and `advanceN` held high, every cycle presents the address loaded on the previous edge. No beat stepping takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| modeInterleave | input | 1 | Beat order strap: 0 linear, 1 interleaved |
| addrIn | input | ADDR_W | External address |
| arrayAddr | output | ADDR_W | Current internal word address |
| burstActive | output | 1 | Beats remain in the current burst |

## Verification
The bench builds the block with `ADDR_W` = 10 and `BEAT_BITS` = 2. With these values the four-beat group and its wrap can be seen directly. The start offsets 0 to 3 can all be combined with a distinctive upper field. Bursts are started from every low offset in both orders, so the carry-free wrap of the linear order and the XOR pattern of the interleaved order can each be told apart. The upper bits are set to all ones so that any carry leaking out of the beat field would show at once.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes passed from the control section to the datapath
  typedef struct packed {
    logic load;  // capture the external address, restart at beat 0
    logic step;  // move to the next beat
  } seq_strobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int BEAT_BITS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         procStrobeN,
  input  logic         ctrlStrobeN,
  input  logic         advanceN,
  output seq_strobes_t strobes,
  output logic         burstActive
);
  localparam logic [BEAT_BITS-1:0] LAST_BEAT = '1;

  logic                 loadReq;
  logic                 stepReq;
  logic [BEAT_BITS-1:0] beatsTakenQ;
  logic                 activeQ;

  // A load always wins over an advance
  assign loadReq = !procStrobeN || !ctrlStrobeN;
  assign stepReq = !loadReq && !advanceN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatsTakenQ <= '0;
      activeQ     <= 1'b0;
    end else if (loadReq) begin
      beatsTakenQ <= '0;
      activeQ     <= 1'b1;
    end else if (stepReq && activeQ) begin
      if (beatsTakenQ == LAST_BEAT) begin
        activeQ <= 1'b0;
      end
      beatsTakenQ <= beatsTakenQ + 1'b1;
    end
  end

  assign strobes.load = loadReq;
  assign strobes.step = stepReq;
  assign burstActive  = activeQ;
endmodule

// File: rtl/burst_seq_path.sv
module burst_seq_path
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobes_t      strobes,
  input  logic              modeInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrayAddr
);
  localparam int UPPER_W = ADDR_W - BEAT_BITS;

  logic [ADDR_W-1:0]    baseQ;
  logic [BEAT_BITS-1:0] beatQ;
  logic [BEAT_BITS-1:0] linearLow;
  logic [BEAT_BITS-1:0] interLow;
  logic [BEAT_BITS-1:0] lowOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      beatQ <= '0;
    end else if (strobes.load) begin
      baseQ <= addrIn;
      beatQ <= '0;
    end else if (strobes.step) begin
      beatQ <= beatQ + 1'b1;  // wraps inside the aligned group
    end
  end

  assign linearLow = baseQ[BEAT_BITS-1:0] + beatQ;

  for (genvar b = 0; b < BEAT_BITS; b++) begin : g_inter
    assign interLow[b] = baseQ[b] ^ beatQ[b];
  end

  assign lowOut = modeInterleave ? interLow : linearLow;

  if (UPPER_W > 0) begin : g_upper
    assign arrayAddr = {baseQ[ADDR_W-1:BEAT_BITS], lowOut};
  end else begin : g_noupper
    assign arrayAddr = lowOut;
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              modeInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic              burstActive
);
  seq_strobes_t strobes;

  burst_seq_ctrl #(.BEAT_BITS(BEAT_BITS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .strobes     (strobes),
    .burstActive (burstActive)
  );

  burst_seq_path #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_path (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .modeInterleave (modeInterleave),
    .addrIn         (addrIn),
    .arrayAddr      (arrayAddr)
  );
endmodule

// File: rtl/burst_seq_checker.sv
module burst_seq_checker #(
  parameter int ADDR_W    = 18,
  parameter int BEAT_BITS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              modeInterleave,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] arrayAddr,
  input logic              burstActive
);
  logic [BEAT_BITS-1:0] lowBits;
  logic                 anyStrobe;

  assign lowBits   = arrayAddr[BEAT_BITS-1:0];
  assign anyStrobe = !procStrobeN || !ctrlStrobeN;

  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> (arrayAddr == $past(addrIn)));

  p_load_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> burstActive);

  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStrobe && !advanceN && !modeInterleave) |=>
      (modeInterleave || lowBits == BEAT_BITS'($past(lowBits) + 1'b1)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStrobe && advanceN) |=>
      ($stable(burstActive) &&
       (arrayAddr == $past(arrayAddr) || modeInterleave != $past(modeInterleave))));

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rstN)
    !anyStrobe |=>
      (arrayAddr[ADDR_W-1:BEAT_BITS] == $past(arrayAddr[ADDR_W-1:BEAT_BITS])));

  p_active_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burstActive) |-> ($past(!advanceN) && $past(!anyStrobe)));
endmodule

bind burst_seq burst_seq_checker #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .procStrobeN    (procStrobeN),
  .ctrlStrobeN    (ctrlStrobeN),
  .advanceN       (advanceN),
  .modeInterleave (modeInterleave),
  .addrIn         (addrIn),
  .arrayAddr      (arrayAddr),
  .burstActive    (burstActive)
);

// File: tb/burst_seq_test.sv
module burst_seq_test;
  localparam int AW = 10;
  localparam int BB = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          procStrobeN = 1'b1;
  logic          ctrlStrobeN = 1'b1;
  logic          advanceN = 1'b1;
  logic          modeInterleave = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] arrayAddr;
  logic          burstActive;

  int nChecks = 0;
  int nFails  = 0;

  // Reference state, kept from the requirements
  logic [AW-1:0] mBase = '0;
  logic [BB-1:0] mBeat = '0;
  logic          mAct  = 1'b0;

  burst_seq #(.ADDR_W(AW), .BEAT_BITS(BB)) uut (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .modeInterleave(modeInterleave), .addrIn(addrIn),
    .arrayAddr(arrayAddr), .burstActive(burstActive)
  );

  always #4 clk = ~clk;  // 125 MHz

  initial begin
    #(8 * 100000);
    nFails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  function automatic logic [AW-1:0] expAddr();
    logic [BB-1:0] low;
    low = modeInterleave ? (mBase[BB-1:0] ^ mBeat) : BB'(mBase[BB-1:0] + mBeat);
    return {mBase[AW-1:BB], low};
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] ea;
    ea = expAddr();
    nChecks++;
    if (arrayAddr !== ea || burstActive !== mAct) begin
      nFails++;
      $display("FAIL %s: actual addr=%h active=%b, expected addr=%h active=%b",
               tag, arrayAddr, burstActive, ea, mAct);
    end
  endtask

  // Drive one cycle of inputs, clock it, update the reference, check
  task automatic apply(input logic p, input logic c, input logic a,
                       input logic [AW-1:0] ad, input string tag);
    procStrobeN = p; ctrlStrobeN = c; advanceN = a; addrIn = ad;
    @(posedge clk);
    if (!p || !c) begin
      mBase = ad; mBeat = '0; mAct = 1'b1;
    end else if (!a) begin
      if (mAct && mBeat == '1) mAct = 1'b0;
      mBeat = mBeat + 1'b1;
    end
    #2;
    check(tag);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    mBase = '0; mBeat = '0; mAct = 1'b0;
    check("R1 during reset");
    rstN = 1'b1;
    @(posedge clk); #2;
    check("R1 after reset");
  endtask

  task automatic t_loads();
    apply(1'b0, 1'b1, 1'b1, 10'h2A5, "R2 proc strobe load");
    apply(1'b1, 1'b0, 1'b1, 10'h13C, "R2 ctrl strobe load");
    apply(1'b0, 1'b0, 1'b0, 10'h3F1, "R3 both strobes, advance ignored");
    apply(1'b0, 1'b1, 1'b0, 10'h0C2, "R3 strobe beats advance");
  endtask

  task automatic t_burst(input logic inter);
    modeInterleave = inter;
    for (int s = 0; s < 4; s++) begin
      apply(1'b0, 1'b1, 1'b1, {8'hFF, 2'(s)}, inter ? "R5 load" : "R4 load");
      for (int k = 0; k < 3; k++)
        apply(1'b1, 1'b1, 1'b0, '0, inter ? "R5 interleaved beat R7" : "R4 linear beat R7");
      apply(1'b1, 1'b1, 1'b0, '0, "R8 wrap to first beat, R9 flag falls");
      apply(1'b1, 1'b1, 1'b0, '0, "R9 flag stays low after wrap");
    end
    modeInterleave = 1'b0;
  endtask

  task automatic t_suspend();
    apply(1'b1, 1'b0, 1'b1, 10'h155, "R2 load before suspend");
    apply(1'b1, 1'b1, 1'b0, 10'h0AA, "R4 first step");
    apply(1'b1, 1'b1, 1'b1, 10'h3FF, "R6 suspend holds");
    apply(1'b1, 1'b1, 1'b1, 10'h000, "R6 suspend holds again");
    apply(1'b1, 1'b1, 1'b0, 10'h000, "R4 resume after suspend");
  endtask

  task automatic t_strapped();
    for (int i = 0; i < 8; i++)
      apply(1'b1, 1'b0, 1'b1, 10'(37 * i + 5), "R10 strapped single access");
  endtask

  initial begin
    t_reset();
    t_loads();
    t_burst(1'b0);
    t_burst(1'b1);
    t_suspend();
    t_strapped();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule